// File: doc/BRIEF.md
# DRAM Command Phase Steerer

The steerer sits between a DRAM controller's command sources and a multi-phase command bus of the DFI kind. Each clock, every phase of the bus has its own select code. The code names either no command at all, or one of three command sources: a general command port, a request port and a refresh port. Each source offers active-high cas/ras/we intents, a bank field and an address, together with its own valid and ready flags.

For each phase the block drives active-low cas_n, ras_n and we_n, a per-rank active-low chip select, a bank address and an address. A source's command reaches a phase only when that source is both valid and ready. When there is more than one rank, the top bits of the source's bank field choose the rank and the rest form the bank address. A refresh drives every rank's chip select. Clock enable, termination and the memory reset pin are held high on every phase, because dynamic termination is not supported. All command outputs are registered one clock behind their inputs.

Top module: `cmd_phase_steer`

## Requirements
- R1: A phase whose select code is 0 (no-operation) carries an inactive command one clock later: cas_n, ras_n and we_n all 1, every chip select of that phase 1, bank and address 0.
- R2: Select codes 1, 2 and 3 pick the command source, the request source and the refresh source (source index 0, 1 and 2). The chosen command is driven only when that source's valid and ready are both 1. Otherwise the phase carries the inactive command of R1.
- R3: A driven command puts cas_n, ras_n and we_n at the inverse of the source's cas, ras and we bits, and copies the source address to the phase address.
- R4: With NRANKS greater than 1, the bank field is BANK_W+log2(NRANKS) bits wide. Its top log2(NRANKS) bits give rank r, and only chip select bit r of the phase goes low. Its low BANK_W bits form the bank address.
- R5: With NRANKS equal to 1, the whole bank field passes unchanged to the bank address, and the single chip select goes low on a driven command.
- R6: A driven refresh (select code 3) on any phase, phase 0 included, drives every chip select of that phase low.
- R7: reset_n is 1 on every phase at all times.
- R8: cke is 1 on every phase and every rank at all times.
- R9: odt is 1 on every phase and every rank at all times.
- R10: Outputs change one clock after the select and source inputs are sampled. A synchronous reset puts the inactive command on every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phaseSel | input | 2*NPHASES | Select code per phase, phase p at bits [2p+1:2p] |
| srcValid | input | 3 | Valid flag per source (0 command, 1 request, 2 refresh) |
| srcReady | input | 3 | Ready flag per source |
| srcCas | input | 3 | Column strobe intent per source, active high |
| srcRas | input | 3 | Row strobe intent per source, active high |
| srcWe | input | 3 | Write enable intent per source, active high |
| srcBank | input | 3*BA_IN_W | Bank field per source (rank bits on top when multi-rank) |
| srcAddr | input | 3*ADDR_W | Address per source |
| casN | output | NPHASES | Column strobe per phase, active low |
| rasN | output | NPHASES | Row strobe per phase, active low |
| weN | output | NPHASES | Write enable per phase, active low |
| csN | output | NPHASES*NRANKS | Chip select per phase and rank, bit p*NRANKS+r, active low |
| bankOut | output | NPHASES*BANK_W | Bank address per phase |
| addrOut | output | NPHASES*ADDR_W | Address per phase |
| cke | output | NPHASES*NRANKS | Clock enable per phase and rank |
| odt | output | NPHASES*NRANKS | Termination per phase and rank |
| resetN | output | NPHASES | Memory reset per phase, active low |

## Verification
The assertions assume that the rank bits of a bank field never name a rank at or above NRANKS, so a normal command always finds exactly one chip select to drive low. They also assume that select codes are always defined values. The random stimulus draws rank bits only from the valid range, because the default rank count is a power of two. It draws select codes, valid and ready flags independently, so gated, idle and refresh phases occur side by side on the same cycle. Directed cases add the all-idle bus, refresh on phase 0, and each rank in turn.

// File: rtl/steer_pkg.sv
package steer_pkg;
  localparam int NSRC = 3;

  typedef enum logic [1:0] {
    SEL_NOP = 2'd0,
    SEL_CMD = 2'd1,
    SEL_REQ = 2'd2,
    SEL_REF = 2'd3
  } selCode_t;

  typedef struct packed {
    logic       drive;
    logic       refresh;
    logic [1:0] src;
  } phaseStrobe_t;
endpackage

// File: rtl/steer_ctrl.sv
module steer_ctrl
  import steer_pkg::*;
#(
  parameter int NPHASES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [2*NPHASES-1:0]        phaseSel,
  input  logic [NSRC-1:0]             srcValid,
  input  logic [NSRC-1:0]             srcReady,
  output phaseStrobe_t [NPHASES-1:0]  strobe
);
  for (genvar p = 0; p < NPHASES; p++) begin : g_phase
    selCode_t   code;
    logic [1:0] srcIdx;
    assign code   = selCode_t'(phaseSel[2*p +: 2]);
    assign srcIdx = (code == SEL_NOP) ? 2'd0 : 2'(code - 2'd1);

    always_comb begin
      strobe[p].src     = srcIdx;
      strobe[p].refresh = (code == SEL_REF);
      strobe[p].drive   = (code != SEL_NOP) && srcValid[srcIdx] && srcReady[srcIdx];
    end

    // R1
    nop_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
      (phaseSel[2*p +: 2] == 2'd0) |-> !strobe[p].drive);
    // R2
    gate_chk: assert property (@(posedge clk) disable iff (rst)
      strobe[p].drive |-> (srcValid[strobe[p].src] && srcReady[strobe[p].src]));
  end
endmodule

// File: rtl/steer_datapath.sv
module steer_datapath
  import steer_pkg::*;
#(
  parameter int NPHASES = 2,
  parameter int NRANKS  = 2,
  parameter int BANK_W  = 3,
  parameter int ADDR_W  = 14,
  localparam int RANK_W  = (NRANKS > 1) ? $clog2(NRANKS) : 1,
  localparam int BA_IN_W = BANK_W + ((NRANKS > 1) ? RANK_W : 0)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  phaseStrobe_t [NPHASES-1:0]  strobe,
  input  logic [NSRC-1:0]             srcCas,
  input  logic [NSRC-1:0]             srcRas,
  input  logic [NSRC-1:0]             srcWe,
  input  logic [NSRC*BA_IN_W-1:0]     srcBank,
  input  logic [NSRC*ADDR_W-1:0]      srcAddr,
  output logic [NPHASES-1:0]          casN,
  output logic [NPHASES-1:0]          rasN,
  output logic [NPHASES-1:0]          weN,
  output logic [NPHASES*NRANKS-1:0]   csN,
  output logic [NPHASES*BANK_W-1:0]   bankOut,
  output logic [NPHASES*ADDR_W-1:0]   addrOut
);
  for (genvar p = 0; p < NPHASES; p++) begin : g_phase
    logic               nCas, nRas, nWe;
    logic [NRANKS-1:0]  nCs;
    logic [BANK_W-1:0]  nBank;
    logic [ADDR_W-1:0]  nAddr;
    logic [BA_IN_W-1:0] field;
    logic [RANK_W-1:0]  rankSel;

    assign field   = srcBank[strobe[p].src*BA_IN_W +: BA_IN_W];
    assign rankSel = (NRANKS > 1) ? field[BA_IN_W-1 -: RANK_W] : '0;

    always_comb begin
      nCas  = 1'b1;
      nRas  = 1'b1;
      nWe   = 1'b1;
      nCs   = '1;
      nBank = '0;
      nAddr = '0;
      if (strobe[p].drive) begin
        nCas  = ~srcCas[strobe[p].src];
        nRas  = ~srcRas[strobe[p].src];
        nWe   = ~srcWe[strobe[p].src];
        nBank = field[BANK_W-1:0];
        nAddr = srcAddr[strobe[p].src*ADDR_W +: ADDR_W];
        if (strobe[p].refresh || NRANKS == 1) begin
          nCs = '0;
        end else begin
          for (int r = 0; r < NRANKS; r++) begin
            if (int'(rankSel) == r) nCs[r] = 1'b0;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        casN[p]                    <= 1'b1;
        rasN[p]                    <= 1'b1;
        weN[p]                     <= 1'b1;
        csN[p*NRANKS +: NRANKS]    <= '1;
        bankOut[p*BANK_W +: BANK_W] <= '0;
        addrOut[p*ADDR_W +: ADDR_W] <= '0;
      end else begin
        casN[p]                    <= nCas;
        rasN[p]                    <= nRas;
        weN[p]                     <= nWe;
        csN[p*NRANKS +: NRANKS]    <= nCs;
        bankOut[p*BANK_W +: BANK_W] <= nBank;
        addrOut[p*ADDR_W +: ADDR_W] <= nAddr;
      end
    end

    // R1
    idle_cmd_chk: assert property (@(posedge clk) disable iff (rst)
      !strobe[p].drive |=> (casN[p] && rasN[p] && weN[p] && (&csN[p*NRANKS +: NRANKS])));
    // R6
    refresh_cs_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe[p].drive && strobe[p].refresh) |=> (csN[p*NRANKS +: NRANKS] == '0));
    // R4
    one_rank_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe[p].drive && !strobe[p].refresh) |=>
        ($countones(~csN[p*NRANKS +: NRANKS]) == 1));
  end
endmodule

// File: rtl/cmd_phase_steer.sv
module cmd_phase_steer
  import steer_pkg::*;
#(
  parameter int NPHASES = 2,
  parameter int NRANKS  = 2,
  parameter int BANK_W  = 3,
  parameter int ADDR_W  = 14,
  localparam int RANK_W  = (NRANKS > 1) ? $clog2(NRANKS) : 1,
  localparam int BA_IN_W = BANK_W + ((NRANKS > 1) ? RANK_W : 0)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [2*NPHASES-1:0]      phaseSel,
  input  logic [2:0]                srcValid,
  input  logic [2:0]                srcReady,
  input  logic [2:0]                srcCas,
  input  logic [2:0]                srcRas,
  input  logic [2:0]                srcWe,
  input  logic [3*BA_IN_W-1:0]      srcBank,
  input  logic [3*ADDR_W-1:0]       srcAddr,
  output logic [NPHASES-1:0]        casN,
  output logic [NPHASES-1:0]        rasN,
  output logic [NPHASES-1:0]        weN,
  output logic [NPHASES*NRANKS-1:0] csN,
  output logic [NPHASES*BANK_W-1:0] bankOut,
  output logic [NPHASES*ADDR_W-1:0] addrOut,
  output logic [NPHASES*NRANKS-1:0] cke,
  output logic [NPHASES*NRANKS-1:0] odt,
  output logic [NPHASES-1:0]        resetN
);
  phaseStrobe_t [NPHASES-1:0] strobe;

  steer_ctrl #(.NPHASES(NPHASES)) u_ctrl (
    .clk(clk), .rst(rst), .phaseSel(phaseSel),
    .srcValid(srcValid), .srcReady(srcReady), .strobe(strobe)
  );

  steer_datapath #(.NPHASES(NPHASES), .NRANKS(NRANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .srcCas(srcCas), .srcRas(srcRas), .srcWe(srcWe),
    .srcBank(srcBank), .srcAddr(srcAddr),
    .casN(casN), .rasN(rasN), .weN(weN), .csN(csN),
    .bankOut(bankOut), .addrOut(addrOut)
  );

  // Static pins: no power-down, no dynamic termination, memory never held in reset.
  assign cke    = '1;
  assign odt    = '1;
  assign resetN = '1;
endmodule

// File: tb/sim_cmd_phase_steer.sv
`timescale 1ns/1ps
module sim_cmd_phase_steer;
  localparam int NP = 2, NR = 2, BW = 3, AW = 14;
  localparam int BIW = BW + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [2*NP-1:0] phaseSel = '0;
  logic [2:0] srcValid = '0, srcReady = '0, srcCas = '0, srcRas = '0, srcWe = '0;
  logic [3*BIW-1:0] srcBank = '0;
  logic [3*BW-1:0]  srcBank1 = '0;
  logic [3*AW-1:0]  srcAddr = '0;

  logic [NP-1:0] casN, rasN, weN, resetN;
  logic [NP*NR-1:0] csN, cke, odt;
  logic [NP*BW-1:0] bankOut;
  logic [NP*AW-1:0] addrOut;
  logic [NP-1:0] casN1, rasN1, weN1, resetN1;
  logic [NP-1:0] csN1, cke1, odt1;
  logic [NP*BW-1:0] bankOut1;
  logic [NP*AW-1:0] addrOut1;

  cmd_phase_steer #(.NPHASES(NP), .NRANKS(NR), .BANK_W(BW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .phaseSel(phaseSel), .srcValid(srcValid), .srcReady(srcReady),
    .srcCas(srcCas), .srcRas(srcRas), .srcWe(srcWe), .srcBank(srcBank), .srcAddr(srcAddr),
    .casN(casN), .rasN(rasN), .weN(weN), .csN(csN), .bankOut(bankOut), .addrOut(addrOut),
    .cke(cke), .odt(odt), .resetN(resetN));

  cmd_phase_steer #(.NPHASES(NP), .NRANKS(1), .BANK_W(BW), .ADDR_W(AW)) u1 (
    .clk(clk), .rst(rst), .phaseSel(phaseSel), .srcValid(srcValid), .srcReady(srcReady),
    .srcCas(srcCas), .srcRas(srcRas), .srcWe(srcWe), .srcBank(srcBank1), .srcAddr(srcAddr),
    .casN(casN1), .rasN(rasN1), .weN(weN1), .csN(csN1), .bankOut(bankOut1), .addrOut(addrOut1),
    .cke(cke1), .odt(odt1), .resetN(resetN1));

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected state of one phase, computed from the requirements.
  typedef struct packed {
    logic [2:0]    cmdN;
    logic [NR-1:0] cs;
    logic [BW-1:0] bank;
    logic [AW-1:0] addr;
    logic [BW-1:0] bank1;
    logic          cs1;
  } exp_t;

  function automatic exp_t model(int p, logic [2*NP-1:0] sel, logic [2:0] v, logic [2:0] r,
                                 logic [2:0] c, logic [2:0] ra, logic [2:0] w,
                                 logic [3*BIW-1:0] b, logic [3*BW-1:0] b1, logic [3*AW-1:0] a);
    exp_t e;
    int code = int'(sel[2*p +: 2]);
    int s;
    logic [BIW-1:0] f;
    e.cmdN = 3'b111; e.cs = '1; e.bank = '0; e.addr = '0; e.bank1 = '0; e.cs1 = 1'b1;
    if (code != 0) begin
      s = code - 1;
      if (v[s] && r[s]) begin
        e.cmdN  = ~{c[s], ra[s], w[s]};
        f       = b[s*BIW +: BIW];
        e.bank  = f[BW-1:0];
        e.addr  = a[s*AW +: AW];
        e.bank1 = b1[s*BW +: BW];
        e.cs1   = 1'b0;
        if (code == 3) e.cs = '0;
        else e.cs[f[BIW-1]] = 1'b0;
      end
    end
    return e;
  endfunction

  task automatic checkAll(string cmdTag);
    exp_t e;
    for (int p = 0; p < NP; p++) begin
      e = model(p, phaseSel, srcValid, srcReady, srcCas, srcRas, srcWe, srcBank, srcBank1, srcAddr);
      check({cmdTag, " cmd"}, {61'd0, casN[p], rasN[p], weN[p]}, {61'd0, e.cmdN});
      check(int'(phaseSel[2*p +: 2]) == 3 ? "R6 cs" : "R4 cs", 64'(csN[p*NR +: NR]), 64'(e.cs));
      check("R4 bank", 64'(bankOut[p*BW +: BW]), 64'(e.bank));
      check("R3 addr", 64'(addrOut[p*AW +: AW]), 64'(e.addr));
      check("R5 bank", 64'(bankOut1[p*BW +: BW]), 64'(e.bank1));
      check("R5 cs", 64'(csN1[p]), 64'(e.cs1));
    end
    check("R7 resetN", 64'({resetN, resetN1}), 64'({2*NP{1'b1}}));
    check("R8 cke", 64'({cke, cke1}), 64'({NP*NR+NP{1'b1}}));
    check("R9 odt", 64'({odt, odt1}), 64'({NP*NR+NP{1'b1}}));
  endtask

  // Inputs change at the falling edge; the register takes them at the next rising edge (R10).
  task automatic step(string cmdTag);
    @(posedge clk);
    #1;
    checkAll(cmdTag);
    @(negedge clk);
  endtask

  task automatic randomize_inputs();
    phaseSel = 4'($urandom);
    srcValid = 3'($urandom);
    srcReady = 3'($urandom);
    srcCas   = 3'($urandom);
    srcRas   = 3'($urandom);
    srcWe    = 3'($urandom);
    srcBank  = 12'($urandom);
    srcBank1 = 9'($urandom);
    srcAddr  = 42'({$urandom, $urandom});
  endtask

  initial begin
    void'($urandom(32'd1234));
    // R10: reset forces the inactive command even with live inputs
    @(negedge clk);
    rst = 1'b1;
    phaseSel = 4'b1111; srcValid = '1; srcReady = '1; srcCas = '1;
    @(posedge clk); #1;
    check("R10 reset cmd", 64'({casN, rasN, weN}), 64'({3*NP{1'b1}}));
    check("R10 reset cs", 64'(csN), 64'({NP*NR{1'b1}}));
    check("R10 reset addr", 64'(addrOut), 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // R1: all phases no-operation while sources are live
    phaseSel = '0; srcValid = '1; srcReady = '1; srcCas = '1; srcRas = '1; srcWe = '1;
    srcAddr = '1; srcBank = '1;
    step("R1");

    // R2: refresh selected but not ready, command source valid but not ready
    phaseSel = {2'd1, 2'd3}; srcValid = 3'b111; srcReady = 3'b000;
    step("R2");

    // R6: refresh on phase 0, rank bits point at rank 1
    phaseSel = {2'd0, 2'd3}; srcReady = 3'b111; srcCas = 3'b100; srcRas = 3'b100; srcWe = 3'b000;
    srcBank = {4'b1010, 4'b0001, 4'b0010};
    step("R6");

    // R4: rank 0 on phase 0 via command source, rank 1 on phase 1 via request source
    phaseSel = {2'd2, 2'd1};
    srcBank = {4'b0000, 4'b1101, 4'b0110};
    srcAddr = {14'h0aaa, 14'h1555, 14'h0123};
    srcCas = 3'b001; srcRas = 3'b010; srcWe = 3'b011;
    step("R3");
    phaseSel = {2'd1, 2'd2};
    step("R3");

    // R10: command appears one clock late, then NOP clears it
    phaseSel = '0;
    step("R1");

    for (int i = 0; i < 600; i++) begin
      randomize_inputs();
      step("R2");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule